// File: doc/BRIEF.md
# Bias DAC serial frame writer

This block loads an 8-bit code into a bias-voltage DAC that sits on a two-wire clock-and-data serial link. The link is write-only, and the block cannot drive its wires directly. Both wires are two bits of a power-control register. Every change of wire level therefore leaves the block as one complete register write: a fixed register address and an 8-bit value. That value carries the two wire bits merged into a base byte supplied by the caller, so the other power-control bits keep their settings.

A caller pulses `start_i` and presents the base byte and the DAC code. The block latches both. It then walks through the frame: a start condition, the command byte 0x9C, a sub-address byte 0x00, and the DAC code. Each byte is followed by a clocked acknowledge slot that is never read back. A stop condition ends the frame. Each write is offered on a valid/ready port. Once the downstream side accepts a write, the block waits a programmable number of cycles before it offers the next one. This wait gives the slow serial device its settling time. A one-cycle `done_o` pulse marks the end of the frame.

Top module: `bias_dac_link`

## Requirements
- R1: After reset, and until a start is seen, `wr_valid_o` and `done_o` are both 0.
- R2: Every write carries address REG_ADDR (default 3). Every data bit other than bit 0 and bit 1 equals the base byte latched at start.
- R3: Bit 0 of the written data is the serial clock and bit 1 is the serial data line. The frame opens with three writes whose (clock, data) pairs are (1,1), then (1,0), then (0,0).
- R4: Each byte bit takes three writes, MSB first. The first has the bit on the data line with the clock at 0. The second has the same data with the clock at 1. The third has the same data with the clock at 0 again. The data line never changes while the clock is 1 within a byte.
- R5: After each byte comes an acknowledge slot. It is three writes shaped like a bit (clock 0, 1, 0) with the data line held at 0.
- R6: A frame is exactly 87 writes. The bytes go out in this order: 0x9C, then 0x00, then the DAC code latched at start.
- R7: The frame closes with three writes whose (clock, data) pairs are (0,0), then (1,0), then (1,1).
- R8: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the request holds with its address and data unchanged. A write is taken on a cycle where both are 1.
- R9: After a write is accepted, `wr_valid_o` stays 0 for exactly HOLD_CYC cycles before the next write of the same frame is offered.
- R10: A start pulse during a frame is ignored. It does not change the frame in progress, and no further write or frame follows that frame's `done_o`.
- R11: `done_o` is 1 for exactly one cycle per frame. It comes HOLD_CYC+1 cycles after the cycle in which the final stop write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| base_i | input | REG_W | Base byte for the power-control register, sampled at start |
| value_i | input | 8 | DAC code, sampled at start |
| wr_valid_o | output | 1 | Register write request |
| wr_ready_i | input | 1 | Downstream accepts the request |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | REG_W | Register data: base byte with the clock and data wire bits merged in |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A wrong step counter shows up as a wrong (clock, data) pair at the first write where it goes astray. A wrong segment counter has the same effect, and so does a dropped or extra write; it also shows as a write count other than 87 when `done_o` fires. A wrong hold timer or handshake state shows within one write: the spacing of valid from the previous acceptance is wrong, or a stalled request changes. A start that is wrongly accepted during a frame shows as altered base bits or code bits in the next write, or as writes that appear after `done_o`. Every DAC code is swept against a computed frame, and some frames run with a stalling ready.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   typedef enum logic [1:0] {
      CTL_IDLE,
      CTL_SEND,
      CTL_HOLD
   } ctl_e;

   typedef enum logic [1:0] {
      SEG_START,
      SEG_DATA,
      SEG_STOP
   } seg_e;

   localparam int SER_BYTE_W = 8;
   localparam int STEPS_PER_PART = 3;

endpackage

// File: rtl/bdl_hold_timer.sv
module bdl_hold_timer #(
   parameter int HOLD_CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic expire_o
);

   localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1;

   generate
      if (HOLD_CYC < 1) begin : g_bad
         $error("bdl_hold_timer: HOLD_CYC must be at least 1");
      end

      if (HOLD_CYC == 1) begin : g_single
         logic unused_inputs;
         assign unused_inputs = load_i ^ clk ^ rst_n;
         assign expire_o = run_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load_i) begin
               cnt_q <= CNT_W'(HOLD_CYC);
            end else if (run_i && cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign expire_o = run_i && (cnt_q == CNT_W'(1));
      end
   endgenerate

endmodule

// File: rtl/bdl_frame_seq.sv
module bdl_frame_seq
   import bdl_pkg::*;
#(
   parameter logic [SER_BYTE_W-1:0] CMD_BYTE = 8'h9C,
   parameter logic [SER_BYTE_W-1:0] SUB_BYTE = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init_i,
   input  logic                  adv_i,
   input  logic [SER_BYTE_W-1:0] value_i,
   output logic                  line_clk_o,
   output logic                  line_dat_o,
   output logic                  last_o
);

   localparam int NUM_BYTES = 3;
   localparam int SLOT_N    = SER_BYTE_W + 1;
   localparam int SLOT_W    = $clog2(SLOT_N);
   localparam int BI_W      = $clog2(NUM_BYTES);
   localparam int PH_W      = $clog2(STEPS_PER_PART);
   localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(STEPS_PER_PART - 1);
   localparam logic [SLOT_W-1:0] SLOT_ACK  = SLOT_W'(SER_BYTE_W);
   localparam logic [BI_W-1:0]   BYTE_LAST = BI_W'(NUM_BYTES - 1);

   seg_e              seg_q;
   logic [PH_W-1:0]   ph_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BI_W-1:0]   bi_q;

   logic [SER_BYTE_W-1:0] cur_byte;
   logic                  bit_val;

   always_comb begin
      case (bi_q)
         BI_W'(0): cur_byte = CMD_BYTE;
         BI_W'(1): cur_byte = SUB_BYTE;
         default:  cur_byte = value_i;
      endcase
   end

   always_comb begin
      bit_val = 1'b0;
      for (int i = 0; i < SER_BYTE_W; i++) begin
         if (slot_q == SLOT_W'(i)) bit_val = cur_byte[SER_BYTE_W-1-i];
      end
   end

   always_comb begin
      line_clk_o = 1'b0;
      line_dat_o = 1'b0;
      case (seg_q)
         SEG_START: begin
            line_clk_o = (ph_q != PH_LAST);
            line_dat_o = (ph_q == PH_W'(0));
         end
         SEG_DATA: begin
            line_clk_o = (ph_q == PH_W'(1));
            line_dat_o = (slot_q == SLOT_ACK) ? 1'b0 : bit_val;
         end
         SEG_STOP: begin
            line_clk_o = (ph_q != PH_W'(0));
            line_dat_o = (ph_q == PH_LAST);
         end
         default: begin
            line_clk_o = 1'b0;
            line_dat_o = 1'b0;
         end
      endcase
   end

   assign last_o = (seg_q == SEG_STOP) && (ph_q == PH_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         seg_q  <= SEG_START;
         ph_q   <= '0;
         slot_q <= '0;
         bi_q   <= '0;
      end else if (adv_i) begin
         if (ph_q == PH_LAST) begin
            ph_q <= '0;
            case (seg_q)
               SEG_START: seg_q <= SEG_DATA;
               SEG_DATA: begin
                  if (slot_q == SLOT_ACK) begin
                     slot_q <= '0;
                     if (bi_q == BYTE_LAST) seg_q <= SEG_STOP;
                     else bi_q <= bi_q + 1'b1;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end
               default: seg_q <= SEG_START;
            endcase
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end
   end

   AST_ONE_LINE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> ($countones({line_clk_o, line_dat_o} ^ $past({line_clk_o, line_dat_o})) <= 1)); // R4

   AST_DATA_STILL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && seg_q == SEG_DATA && line_clk_o) |=> (line_dat_o == $past(line_dat_o))); // R4

endmodule

// File: rtl/bias_dac_link.sv
module bias_dac_link
   import bdl_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter int              REG_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h03,
   parameter int              CLK_BIT  = 0,
   parameter int              DAT_BIT  = 1,
   parameter int              HOLD_CYC = 2500,
   parameter logic [7:0]      CMD_BYTE = 8'h9C,
   parameter logic [7:0]      SUB_BYTE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [REG_W-1:0]  base_i,
   input  logic [7:0]        value_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [REG_W-1:0]  wr_data_o,
   output logic              done_o
);

   generate
      if (REG_W < 2) begin : g_bad_width
         $error("bias_dac_link: REG_W must hold both wire bits");
      end
      if (CLK_BIT == DAT_BIT || CLK_BIT >= REG_W || DAT_BIT >= REG_W) begin : g_bad_bits
         $error("bias_dac_link: wire bit positions must be distinct and inside REG_W");
      end
   endgenerate

   ctl_e              state_q;
   logic [REG_W-1:0]  base_q;
   logic [7:0]        value_q;
   logic              done_q;

   logic line_clk, line_dat, last_step, hold_done;
   logic seq_init, seq_adv, tmr_load, tmr_run;

   assign seq_init = (state_q == CTL_IDLE) && start_i;
   assign tmr_load = (state_q == CTL_SEND) && wr_ready_i;
   assign tmr_run  = (state_q == CTL_HOLD);
   assign seq_adv  = tmr_run && hold_done && !last_step;

   bdl_frame_seq #(
      .CMD_BYTE (CMD_BYTE),
      .SUB_BYTE (SUB_BYTE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (seq_init),
      .adv_i      (seq_adv),
      .value_i    (value_q),
      .line_clk_o (line_clk),
      .line_dat_o (line_dat),
      .last_o     (last_step)
   );

   bdl_hold_timer #(
      .HOLD_CYC (HOLD_CYC)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .run_i    (tmr_run),
      .expire_o (hold_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CTL_IDLE;
         base_q  <= '0;
         value_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            CTL_IDLE: begin
               if (start_i) begin
                  base_q  <= base_i;
                  value_q <= value_i;
                  state_q <= CTL_SEND;
               end
            end
            CTL_SEND: begin
               if (wr_ready_i) state_q <= CTL_HOLD;
            end
            CTL_HOLD: begin
               if (hold_done) begin
                  if (last_step) begin
                     state_q <= CTL_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= CTL_SEND;
                  end
               end
            end
            default: state_q <= CTL_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_data_o          = base_q;
      wr_data_o[CLK_BIT] = line_clk;
      wr_data_o[DAT_BIT] = line_dat;
   end

   assign wr_addr_o  = REG_ADDR;
   assign wr_valid_o = (state_q == CTL_SEND);
   assign done_o     = done_q;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o))); // R8

   AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_ready_i) |=> !wr_valid_o); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R11

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CTL_IDLE && start_i) |=> (base_q == $past(base_q) && value_q == $past(value_q))); // R10

endmodule

// File: tb/bias_dac_link_test.sv
module bias_dac_link_test;

   localparam int H = 3;
   localparam int FRAME_N = 87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] base_i = 8'h00;
   logic [7:0] value_i = 8'h00;
   logic       wr_valid_o;
   logic       wr_ready_i = 1'b1;
   logic [7:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic       done_o;

   always #2 clk = ~clk;

   bias_dac_link #(.HOLD_CYC(H)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .base_i     (base_i),
      .value_i    (value_i),
      .wr_valid_o (wr_valid_o),
      .wr_ready_i (wr_ready_i),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o),
      .done_o     (done_o)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] e_val, e_base;
   int widx = 0;
   int last_acc = 0;
   int done_cnt = 0;
   bit stall = 0;
   logic [15:0] lf = 16'hACE1;

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // returns {dat, clk} expected for step s of a frame carrying code v
   function automatic logic [1:0] exp_lines(input int s, input logic [7:0] v);
      int k, slot, ph, by, bt;
      logic [7:0] b;
      logic d, c;
      if (s < 3) begin
         if (s == 0) return 2'b11;
         if (s == 1) return 2'b01;
         return 2'b00;
      end
      if (s >= 84) begin
         if (s == 84) return 2'b00;
         if (s == 85) return 2'b01;
         return 2'b11;
      end
      k = s - 3;
      slot = k / 3;
      ph = k % 3;
      by = slot / 9;
      bt = slot % 9;
      b = (by == 0) ? 8'h9C : (by == 1) ? 8'h00 : v;
      d = (bt == 8) ? 1'b0 : b[7-bt];
      c = (ph == 1);
      return {d, c};
   endfunction

   function automatic string tag_of(input int s);
      if (s < 3) return "R3";
      if (s >= 84) return "R7";
      if ((((s - 3) / 3) % 9) == 8) return "R5";
      return "R4";
   endfunction

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ready driver, changes away from the sampling edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         wr_ready_i = stall ? lf[0] : 1'b1;
      end
   end

   // monitor
   logic pv = 0, pr = 0, pdone = 0;
   logic [7:0] pdata = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (pv && !pr)
               check(wr_valid_o && wr_data_o == pdata, "R8", "stalled request changed", int'(wr_data_o), int'(pdata));
            if (wr_valid_o && !pv && widx > 0 && widx < FRAME_N)
               check(cyc - last_acc == H + 1, "R9", "valid gap after accept", cyc - last_acc, H + 1);
            if (wr_valid_o && wr_ready_i) begin
               if (widx < FRAME_N) begin
                  logic [1:0] el;
                  el = exp_lines(widx, e_val);
                  check(wr_addr_o == 8'h03, "R2", "write address", int'(wr_addr_o), 3);
                  // R10: base bits come from the byte latched at start
                  check(wr_data_o[7:2] == e_base[7:2], "R2", "base bits", int'(wr_data_o[7:2]), int'(e_base[7:2]));
                  check(wr_data_o[1:0] == el, tag_of(widx), "wire bits", int'(wr_data_o[1:0]), int'(el));
               end else begin
                  check(1'b0, "R6", "write beyond frame", widx, FRAME_N - 1);
               end
               last_acc = cyc;
               widx++;
            end
            if (done_o) begin
               done_cnt++;
               check(widx == FRAME_N, "R6", "writes at done", widx, FRAME_N);
               check(cyc - last_acc == H + 1, "R11", "done delay", cyc - last_acc, H + 1);
               check(!pdone, "R11", "done longer than one cycle", 1, 0);
            end
         end
         pv = wr_valid_o;
         pr = wr_ready_i;
         pdata = wr_data_o;
         pdone = done_o;
      end
   end

   task automatic run_frame(input logic [7:0] v, input logic [7:0] b, input bit st, input bit poke);
      int t;
      e_val = v;
      e_base = b;
      widx = 0;
      done_cnt = 0;
      stall = st;
      @(posedge clk); #1;
      start_i = 1'b1; base_i = b; value_i = v;
      @(posedge clk); #1;
      start_i = 1'b0;
      if (poke) begin
         repeat (40) @(posedge clk);
         #1; start_i = 1'b1; base_i = ~b; value_i = ~v;
         @(posedge clk); #1; start_i = 1'b0;
         repeat (100) @(posedge clk);
         #1; start_i = 1'b1; base_i = b ^ 8'hF0; value_i = v ^ 8'h0F;
         @(posedge clk); #1; start_i = 1'b0;
      end
      t = 0;
      while (done_cnt == 0 && t < 6000) begin
         @(posedge clk);
         t++;
      end
      check(done_cnt == 1, "R11", "done pulses seen", done_cnt, 1);
      repeat (H + 6) @(posedge clk);
      check(widx == FRAME_N && done_cnt == 1, "R10", "activity after done", widx, FRAME_N);
      stall = 0;
   endtask

   initial begin
      #(4 * 195000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_up();
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(!wr_valid_o && !done_o, "R1", "outputs in reset", int'({wr_valid_o, done_o}), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!wr_valid_o && !done_o, "R1", "outputs after reset", int'({wr_valid_o, done_o}), 0);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] vb;
         vb = 8'(v * 37 + 8'h5A);
         run_frame(8'(v), vb, (v % 16) == 5, (v == 77) || (v == 200));
      end
      finish_up();
   end

endmodule